// File: doc/BRIEF.md
# Field-Synchronised VBI Base Register Bank

This block keeps the memory base addresses a video capture engine uses when it stores vertical-blanking data, one for odd fields and one for even fields. Software writes these addresses over a simple register bus. A write never disturbs the address the capture engine is using. The value waits in a shadow copy, and a status flag stays raised until the shadow copies move into the live copies. All slots move together when the capture path signals the first captured data of a new field.

When the capture path takes its timing from external horizontal and vertical sync (separate-sync mode), the even-base slot takes on a second role. It holds a 12-bit line number at which the blanking data ends. The block counts sync lines from the falling edge of vertical sync and emits a one-cycle pulse when that count reaches the programmed line.

Top module: `vbi_base_bank`

## Requirements
- R1: After a synchronous active-low reset, both live base outputs, the end-line value, the line count, the end pulse and the pending flag are zero, and every register read returns zero.
- R2: A bus write to offset 0x44 (odd slot), or to offset 0x40 (even slot) while `ext_sync` is 0, stores the write data with bits [4:0] forced to zero into that slot's shadow copy. The live base output does not change. A read of the slot returns the shadow copy.
- R3: A base write as described in R2 sets the pending flag. The flag is visible on `commit_pending` and as bit 16 of a read at offset 0x08. All other bits of that read are zero.
- R4: A `field_start` pulse copies every shadow copy into its live output on the same clock edge and clears the pending flag.
- R5: When a base write and `field_start` fall on the same edge, the live output takes the previous shadow value, the new value stays in the shadow copy, and the pending flag stays set.
- R6: While `ext_sync` is 1, a write to offset 0x40 loads data bits [11:0] into the end-line value. It changes neither the even shadow copy nor the pending flag. A read of 0x40 then returns the end-line value, zero-extended.
- R7: The line count returns to zero on a clock edge where `vsync` is seen falling. Otherwise it adds one on each edge where `hsync` is seen rising, and it saturates at all ones. A vsync fall takes priority over an hsync rise on the same edge.
- R8: `vbi_end_pulse` is high for exactly one cycle, on the edge where an hsync rise brings the line count equal to a non-zero end-line value. It never pulses when the end-line value is zero.
- R9: Writes to any offset other than 0x40 and 0x44 change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_sync | input | 1 | 1 selects separate-sync mode, in which offset 0x40 holds the end line |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for `bus_addr` (combinational) |
| field_start | input | 1 | First captured data of a new field; commits the shadow copies |
| hsync | input | 1 | Horizontal sync, synchronous to `clk` |
| vsync | input | 1 | Vertical sync, synchronous to `clk` |
| odd_base | output | 32 | Live odd-field base address |
| even_base | output | 32 | Live even-field base address |
| vbi_end_line | output | 12 | Programmed end line |
| commit_pending | output | 1 | Shadow copies are waiting for a field start |
| line_count | output | 12 | Lines counted since the last vsync fall |
| vbi_end_pulse | output | 1 | One-cycle pulse when the count reaches the end line |

## Verification
Every register result appears one clock edge after the cycle that carries its stimulus. A written value shows on `bus_rdata`, a commit shows on the live outputs, and the flag changes on that same edge. The line count and the end pulse update on the edge at which the bench first holds `hsync` high, or `vsync` low after a high level. The bench drives inputs only at falling edges. Its behavioural model advances at each rising edge from the same input values, and every output is compared with the model at the next falling edge. Directed checks with fixed expected constants are taken at those same falling-edge instants.

// File: rtl/vbi_bank_pkg.sv
// Package: shared sizes and register offsets for the VBI base register bank.
// Assumes byte offsets on an 8-bit register address.
package vbi_bank_pkg;
    localparam int BANK_ADDR_W   = 8;
    localparam int BANK_DATA_W   = 32;
    localparam int BANK_LINE_W   = 12;
    localparam int BANK_ALIGN    = 5;     // low address bits forced to zero
    localparam int BANK_FLAG_BIT = 16;    // pending flag position in status word
    localparam int BANK_SLOTS    = 2;     // slot 0 = even field, slot 1 = odd field
    localparam int OFS_STATUS    = 'h08;
    localparam int OFS_SLOT0     = 'h40;
    localparam int OFS_STRIDE    = 'h04;
    localparam int SLOT_EVEN     = 0;
endpackage

// File: rtl/vbi_dbuf_reg.sv
// Module: one double-buffered base register.
// The shadow copy loads aligned data on ld. The live copy takes the old shadow
// value on commit. When both happen on one edge, the new data stays in the shadow.
module vbi_dbuf_reg #(
    parameter int W        = 32,
    parameter int ZERO_LSB = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic         commit,
    input  logic [W-1:0] din,
    output logic [W-1:0] pend_q,
    output logic [W-1:0] act_q
);
    localparam logic [W-1:0] KEEP_MASK = {{(W-ZERO_LSB){1'b1}}, {ZERO_LSB{1'b0}}};

    // Shadow and live storage; the commit reads the shadow value from before this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            act_q  <= '0;
        end else begin
            if (commit) act_q  <= pend_q;
            if (ld)     pend_q <= din & KEEP_MASK;
        end
    end
endmodule

// File: rtl/vbi_line_tracker.sv
// Module: sync line counter with end-of-blanking detection.
// Assumes hsync and vsync are already synchronous to clk. Edges are found
// against a registered copy of each input.
module vbi_line_tracker #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         hsync,
    input  logic         vsync,
    input  logic [W-1:0] end_line,
    output logic [W-1:0] line_count,
    output logic         end_pulse
);
    localparam logic [W-1:0] CNT_MAX = '1;
    localparam logic [W-1:0] CNT_ONE = {{(W-1){1'b0}}, 1'b1};

    logic         hs_q, vs_q;
    logic         hs_rise, vs_fall, at_max;
    logic [W-1:0] next_cnt;

    // Edge detection and the incremented count.
    always_comb begin
        hs_rise  = hsync & ~hs_q;
        vs_fall  = ~vsync & vs_q;
        at_max   = (line_count == CNT_MAX);
        next_cnt = line_count + CNT_ONE;
    end

    // Counter, pulse and the registered copies of the sync inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_q       <= 1'b0;
            vs_q       <= 1'b0;
            line_count <= '0;
            end_pulse  <= 1'b0;
        end else begin
            hs_q      <= hsync;
            vs_q      <= vsync;
            end_pulse <= 1'b0;
            if (vs_fall) begin
                line_count <= '0;
            end else if (hs_rise && !at_max) begin
                line_count <= next_cnt;
                end_pulse  <= (next_cnt == end_line) && (end_line != '0);
            end
        end
    end
endmodule

// File: rtl/vbi_base_bank.sv
// Module: top of the VBI base register bank.
// Decodes bus writes into the double-buffered base slots and the end-line
// register. It keeps the pending flag, muxes reads and hosts the line tracker.
// Assumes a single-cycle write strobe and a combinational read.
module vbi_base_bank
    import vbi_bank_pkg::*;
#(
    parameter int ADDR_W   = BANK_ADDR_W,
    parameter int DATA_W   = BANK_DATA_W,
    parameter int LINE_W   = BANK_LINE_W,
    parameter int ALIGN    = BANK_ALIGN,
    parameter int FLAG_BIT = BANK_FLAG_BIT,
    parameter int SLOTS    = BANK_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ext_sync,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              field_start,
    input  logic              hsync,
    input  logic              vsync,
    output logic [DATA_W-1:0] odd_base,
    output logic [DATA_W-1:0] even_base,
    output logic [LINE_W-1:0] vbi_end_line,
    output logic              commit_pending,
    output logic [LINE_W-1:0] line_count,
    output logic              vbi_end_pulse
);
    localparam logic [ADDR_W-1:0] ADR_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] ADR_EVEN   = ADDR_W'(OFS_SLOT0);

    logic [DATA_W-1:0] slot_pend [SLOTS];
    logic [DATA_W-1:0] slot_act  [SLOTS];
    logic [SLOTS-1:0]  slot_ld;
    logic              end_ld;
    logic [LINE_W-1:0] end_q;

    // One double-buffered slot per field; the even slot yields to the end line in separate-sync mode.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        localparam logic [ADDR_W-1:0] SLOT_ADR = ADDR_W'(OFS_SLOT0 + i * OFS_STRIDE);
        localparam bit SHARED = (i == SLOT_EVEN);

        // Write decode for this slot.
        always_comb begin
            slot_ld[i] = bus_wr && (bus_addr == SLOT_ADR) && !(SHARED && ext_sync);
        end

        vbi_dbuf_reg #(.W(DATA_W), .ZERO_LSB(ALIGN)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .ld     (slot_ld[i]),
            .commit (field_start),
            .din    (bus_wdata),
            .pend_q (slot_pend[i]),
            .act_q  (slot_act[i])
        );
    end

    // End-line write decode.
    always_comb begin
        end_ld = bus_wr && ext_sync && (bus_addr == ADR_EVEN);
    end

    // Pending flag (a write wins over a commit) and the end-line register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            commit_pending <= 1'b0;
            end_q          <= '0;
        end else begin
            if (|slot_ld)         commit_pending <= 1'b1;
            else if (field_start) commit_pending <= 1'b0;
            if (end_ld)           end_q <= bus_wdata[LINE_W-1:0];
        end
    end

    // Read mux: the shadow copy of a slot, the end line, or the status word.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADR_STATUS) bus_rdata[FLAG_BIT] = commit_pending;
        for (int i = 0; i < SLOTS; i++) begin
            if (bus_addr == ADDR_W'(OFS_SLOT0 + i * OFS_STRIDE)) bus_rdata = slot_pend[i];
        end
        if (ext_sync && bus_addr == ADR_EVEN) bus_rdata = DATA_W'(end_q);
    end

    // Output assignments of the live copies.
    always_comb begin
        even_base    = slot_act[SLOT_EVEN];
        odd_base     = slot_act[SLOT_EVEN + 1];
        vbi_end_line = end_q;
    end

    vbi_line_tracker #(.W(LINE_W)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .hsync      (hsync),
        .vsync      (vsync),
        .end_line   (end_q),
        .line_count (line_count),
        .end_pulse  (vbi_end_pulse)
    );
endmodule

// File: rtl/vbi_base_bank_chk.sv
// Checker: temporal properties of the VBI base register bank, bound to the top.
module vbi_base_bank_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int LINE_W = 12,
    parameter int ALIGN  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_sync,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              field_start,
    input logic              vsync,
    input logic [DATA_W-1:0] odd_base,
    input logic [DATA_W-1:0] even_base,
    input logic              commit_pending,
    input logic [LINE_W-1:0] line_count,
    input logic [LINE_W-1:0] vbi_end_line,
    input logic              vbi_end_pulse
);
    logic base_wr;
    logic vs_seen;

    // Base write as seen from the bus ports.
    always_comb begin
        base_wr = bus_wr && ((bus_addr == ADDR_W'('h44)) ||
                             (bus_addr == ADDR_W'('h40) && !ext_sync));
    end

    // Own copy of vsync for fall detection.
    always_ff @(posedge clk) begin
        if (!rst_n) vs_seen <= 1'b0;
        else        vs_seen <= vsync;
    end

    p_live_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !field_start |=> ($stable(odd_base) && $stable(even_base)));

    p_live_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (odd_base[ALIGN-1:0] == '0) && (even_base[ALIGN-1:0] == '0));

    p_write_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr |=> commit_pending);

    p_commit_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (field_start && !base_wr) |=> !commit_pending);

    p_vsync_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!vsync && vs_seen) |=> (line_count == '0));

    p_pulse_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vbi_end_pulse |-> ((line_count == $past(vbi_end_line)) && ($past(vbi_end_line) != '0)));

    p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vbi_end_pulse |=> !vbi_end_pulse);
endmodule

bind vbi_base_bank vbi_base_bank_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .LINE_W (LINE_W),
    .ALIGN  (ALIGN)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ext_sync       (ext_sync),
    .bus_wr         (bus_wr),
    .bus_addr       (bus_addr),
    .field_start    (field_start),
    .vsync          (vsync),
    .odd_base       (odd_base),
    .even_base      (even_base),
    .commit_pending (commit_pending),
    .line_count     (line_count),
    .vbi_end_line   (vbi_end_line),
    .vbi_end_pulse  (vbi_end_pulse)
);

// File: tb/tb_vbi_base_bank.sv
`timescale 1ns/1ps
module tb_vbi_base_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_sync = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = 32'h0;
    logic        field_start = 1'b0;
    logic        hsync = 1'b0;
    logic        vsync = 1'b0;
    logic [31:0] bus_rdata, odd_base, even_base;
    logic [11:0] vbi_end_line, line_count;
    logic        commit_pending, vbi_end_pulse;

    int n_chk = 0;
    int n_fail = 0;
    int n_pulse = 0;
    int pulse_line = -1;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    vbi_base_bank dut (
        .clk(clk), .rst_n(rst_n), .ext_sync(ext_sync), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .field_start(field_start), .hsync(hsync), .vsync(vsync),
        .odd_base(odd_base), .even_base(even_base), .vbi_end_line(vbi_end_line),
        .commit_pending(commit_pending), .line_count(line_count),
        .vbi_end_pulse(vbi_end_pulse)
    );

    // Behavioural reference model, advanced at each rising edge.
    logic [31:0] m_pend_odd, m_pend_even, m_act_odd, m_act_even;
    logic        m_flag, m_hs, m_vs, m_pulse;
    int          m_cnt, m_end;

    always @(posedge clk) begin
        bit hs_r, vs_f, bw;
        if (!rst_n) begin
            m_pend_odd = 0; m_pend_even = 0; m_act_odd = 0; m_act_even = 0;
            m_flag = 0; m_hs = 0; m_vs = 0; m_pulse = 0; m_cnt = 0; m_end = 0;
        end else begin
            hs_r = hsync && !m_hs;
            vs_f = !vsync && m_vs;
            bw = 0;
            if (field_start) begin
                m_act_odd = m_pend_odd; m_act_even = m_pend_even; m_flag = 0;
            end
            if (bus_wr && bus_addr == 8'h44) begin
                m_pend_odd = bus_wdata & 32'hFFFF_FFE0; bw = 1;
            end
            if (bus_wr && bus_addr == 8'h40 && !ext_sync) begin
                m_pend_even = bus_wdata & 32'hFFFF_FFE0; bw = 1;
            end
            if (bus_wr && bus_addr == 8'h40 && ext_sync) m_end = int'(bus_wdata[11:0]);
            if (bw) m_flag = 1;
            m_pulse = 0;
            if (vs_f) m_cnt = 0;
            else if (hs_r && m_cnt < 4095) begin
                m_cnt = m_cnt + 1;
                m_pulse = (m_cnt == m_end) && (m_end != 0);
            end
            m_hs = hsync; m_vs = vsync;
        end
    end

    function automatic logic [31:0] m_read(logic [7:0] a);
        if (a == 8'h44) return m_pend_odd;
        if (a == 8'h40) return ext_sync ? 32'(m_end) : m_pend_even;
        if (a == 8'h08) return {15'd0, m_flag, 16'd0};
        return 32'h0;
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        chk("R4", "odd_base", odd_base, m_act_odd);
        chk("R4", "even_base", even_base, m_act_even);
        chk("R3", "commit_pending", 32'(commit_pending), 32'(m_flag));
        chk("R6", "vbi_end_line", 32'(vbi_end_line), 32'(m_end));
        chk("R7", "line_count", 32'(line_count), 32'(m_cnt));
        chk("R8", "vbi_end_pulse", 32'(vbi_end_pulse), 32'(m_pulse));
        chk("R9", "bus_rdata", bus_rdata, m_read(bus_addr));
        if (vbi_end_pulse) begin
            n_pulse++;
            pulse_line = int'(line_count);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        cyc();
        bus_wr = 0;
    endtask

    task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(req, "read", bus_rdata, exp);
    endtask

    task automatic hs_line();
        hsync = 1; cyc(); cyc();
        hsync = 0; cyc(); cyc();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R1: reset state
        rd("R1", 8'h40, 0); rd("R1", 8'h44, 0); rd("R1", 8'h08, 0);
        chk("R1", "odd_base", odd_base, 0);
        chk("R1", "line_count", 32'(line_count), 0);

        // R2/R3: shadow write, alignment, flag
        wr(8'h44, 32'h1234_567F);
        rd("R2", 8'h44, 32'h1234_5660);
        chk("R2", "odd_base unchanged", odd_base, 0);
        rd("R3", 8'h08, 32'h0001_0000);
        wr(8'h40, 32'hA5A5_A5BF);
        rd("R2", 8'h40, 32'hA5A5_A5A0);
        cyc();

        // R4: commit
        field_start = 1; cyc(); field_start = 0;
        chk("R4", "odd_base", odd_base, 32'h1234_5660);
        chk("R4", "even_base", even_base, 32'hA5A5_A5A0);
        chk("R4", "flag clear", 32'(commit_pending), 0);

        // R5: write on the commit edge
        field_start = 1; wr(8'h44, 32'h0000_1000); field_start = 0;
        chk("R5", "odd_base old", odd_base, 32'h1234_5660);
        chk("R5", "flag held", 32'(commit_pending), 1);
        rd("R5", 8'h44, 32'h0000_1000);
        field_start = 1; cyc(); field_start = 0;
        chk("R5", "odd_base new", odd_base, 32'h0000_1000);

        // R6: end-line write in separate-sync mode
        ext_sync = 1;
        wr(8'h40, 32'hFFFF_F005);
        chk("R6", "end line", 32'(vbi_end_line), 32'h005);
        chk("R6", "flag untouched", 32'(commit_pending), 0);
        rd("R6", 8'h40, 32'h0000_0005);
        ext_sync = 0; rd("R6", 8'h40, 32'hA5A5_A5A0); ext_sync = 1;

        // R9: unmapped write ignored
        wr(8'h50, 32'hDEAD_BEEF);
        rd("R9", 8'h50, 0);
        chk("R9", "flag", 32'(commit_pending), 0);
        chk("R9", "odd_base", odd_base, 32'h0000_1000);

        // R7/R8: line counting from vsync fall to the end line
        vsync = 1; cyc(); cyc(); vsync = 0; cyc();
        chk("R7", "count after vsync fall", 32'(line_count), 0);
        n_pulse = 0;
        for (int i = 0; i < 7; i++) hs_line();
        chk("R7", "count after 7 lines", 32'(line_count), 7);
        chk("R8", "pulse count", 32'(n_pulse), 1);
        chk("R8", "pulse line", 32'(pulse_line), 5);

        // R7: vsync fall and hsync rise on the same edge
        vsync = 1; cyc();
        vsync = 0; hsync = 1; cyc();
        chk("R7", "vsync priority", 32'(line_count), 0);
        hsync = 0; cyc();

        // R8: zero end line never pulses
        wr(8'h40, 32'h0);
        vsync = 1; cyc(); vsync = 0; cyc();
        n_pulse = 0;
        for (int i = 0; i < 4; i++) hs_line();
        chk("R8", "no pulse at zero", 32'(n_pulse), 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule